// File: doc/BRIEF.md
# Dual Timer/Counter with Four Count Structures

This block holds two byte-accessed timer/counters, unit A and unit B. Each unit has a two-bit structure select, a run bit, a source select and an overflow flag. The flag drives that unit's interrupt request. The selected source is either an internal tick or a synchronized external event pin. The internal tick fires on every second system clock. An event is a falling edge on the pin.

There are four count structures:
- a 13-bit count, built from the five low bits of the low byte and the whole high byte;
- a plain 16-bit count;
- an 8-bit count in the low byte that reloads from the high byte when it wraps;
- a split structure, in which unit A becomes two separate 8-bit timers.

In the split structure, the upper half of unit A is gated by unit B's run bit and reports its wraps through unit B's flag. Selecting the split structure on unit B itself freezes unit B.

Software reaches the control bytes and the four count bytes through a small synchronous write port and a combinational read port. The interrupt controller acknowledges a request with a one-cycle pulse.

Top module: `tc_pair`

## Requirements
- R1: After reset, all six registers read 0x00 and both interrupt requests are low. The registers are the control bytes of A and B and the count bytes A-low, A-high, B-low and B-high.
- R2: The register map is as follows. Address 0 is the A control byte and address 1 is the B control byte. Addresses 2, 3, 4 and 5 are A-low, A-high, B-low and B-high. Addresses 6 and 7 read 0x00. In a control byte, bits [1:0] hold the structure (0 = 13-bit, 1 = 16-bit, 2 = 8-bit reload, 3 = split), bit 2 selects the source (1 = external events), bit 3 is run and bit 4 is the flag.
- R3: With run set and the internal source selected, a unit advances once every two clocks. Over 2N consecutive clocks with run set it advances exactly N times. With run clear it does not advance.
- R4: Structure 0 counts in the 13-bit value {high, low[4:0]}. Bits low[7:5] keep their value. The unit overflows when the value goes from 0x1FFF to 0.
- R5: Structure 1 counts in {high, low} and overflows when it goes from 0xFFFF to 0.
- R6: In structure 2 the low byte counts. When it is at 0xFF, the next advance loads it from the high byte and counts as an overflow. The high byte is left unchanged.
- R7: While unit B selects structure 3, unit B's count bytes stay constant.
- R8: While unit A selects structure 3, several things change. A-low wraps 0xFF to 0x00 and sets A's flag. A-high counts internal ticks whenever B's run bit is set, and its wrap sets B's flag. Unit B's own wrap then does not set B's flag.
- R9: With the external source selected, each falling edge on that unit's event pin advances the unit exactly once. The internal tick then does not advance it.
- R10: An overflow sets the unit's flag, and each interrupt request output equals its flag.
- R11: An acknowledge pulse clears the flag. So does a control-byte write with bit 4 at 0. A write with bit 4 at 1 leaves the flag unchanged. An overflow in the same cycle keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| evt_in | input | 2 | External event pins, bit 0 unit A, bit 1 unit B |
| irq_ack | input | 2 | Interrupt acknowledge pulses |
| irq | output | 2 | Interrupt requests |

## Verification
The assertions assume that a count byte is never written in a cycle that the checked property depends on. The reload and hold checks therefore exclude cycles with a write to that unit's count bytes. The stimulus writes count bytes only while the unit is stopped. The acknowledge checks assume that a clear and an overflow can coincide, so they are qualified by the absence of a set event in that cycle. The event pins are driven at least three clocks high and three clocks low, which keeps every falling edge visible through the synchronizer.

// File: rtl/tc_pkg.sv
package tc_pkg;

  typedef enum logic [1:0] {
    TM_13    = 2'd0,
    TM_16    = 2'd1,
    TM_RLD8  = 2'd2,
    TM_SPLIT = 2'd3
  } tc_mode_e;

  typedef struct packed {
    logic [7:0] lo;
    logic [7:0] hi;
    logic       wrap_lo;
    logic       wrap_hi;
  } tc_step_t;

  // One count step for a unit, given its structure and the advance requests.
  function automatic tc_step_t tc_step(tc_mode_e m, logic [7:0] lo, logic [7:0] hi,
                                       logic inc_lo, logic inc_hi);
    tc_step_t r;
    r.lo = lo;
    r.hi = hi;
    r.wrap_lo = 1'b0;
    r.wrap_hi = 1'b0;
    case (m)
      TM_13: begin
        if (inc_lo) begin
          r.lo[4:0] = lo[4:0] + 5'd1;
          if (lo[4:0] == 5'h1F) begin
            r.hi      = hi + 8'd1;
            r.wrap_lo = (hi == 8'hFF);
          end
        end
      end
      TM_16: begin
        if (inc_lo) begin
          {r.hi, r.lo} = {hi, lo} + 16'd1;
          r.wrap_lo    = &{hi, lo};
        end
      end
      TM_RLD8: begin
        if (inc_lo) begin
          if (lo == 8'hFF) begin
            r.lo      = hi;
            r.wrap_lo = 1'b1;
          end else begin
            r.lo = lo + 8'd1;
          end
        end
      end
      default: begin
        if (inc_lo) begin
          r.lo      = lo + 8'd1;
          r.wrap_lo = &lo;
        end
        if (inc_hi) begin
          r.hi      = hi + 8'd1;
          r.wrap_hi = &hi;
        end
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tc_tick_gen.sv
module tc_tick_gen (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;
  end

  assign tick = phase_q;
endmodule

// File: rtl/tc_edge_sync.sv
module tc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  localparam int LEN = STAGES + 1;
  logic [LEN-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[LEN-2:0], pin};
  end

  // Oldest sample high, newer one low: one falling edge seen.
  assign fall = sh_q[LEN-1] & ~sh_q[LEN-2];
endmodule

// File: rtl/tc_count_core.sv
module tc_count_core
  import tc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  tc_mode_e   mode,
  input  logic       inc_lo,
  input  logic       inc_hi,
  input  logic       wr_lo,
  input  logic       wr_hi,
  input  logic [7:0] wdata,
  output logic [7:0] lo_q,
  output logic [7:0] hi_q,
  output logic       wrap_lo,
  output logic       wrap_hi
);
  tc_step_t nxt;
  logic     sw_wr;

  assign nxt   = tc_step(mode, lo_q, hi_q, inc_lo, inc_hi);
  assign sw_wr = wr_lo | wr_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (sw_wr) begin
      if (wr_lo) lo_q <= wdata;
      if (wr_hi) hi_q <= wdata;
    end else begin
      lo_q <= nxt.lo;
      hi_q <= nxt.hi;
    end
  end

  assign wrap_lo = nxt.wrap_lo & ~sw_wr;
  assign wrap_hi = nxt.wrap_hi & ~sw_wr;
endmodule

// File: rtl/tc_pair.sv
module tc_pair
  import tc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUNITS      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [1:0] evt_in,
  input  logic [1:0] irq_ack,
  output logic [1:0] irq
);
  localparam int FLAG_BIT = 4;
  localparam int RUN_BIT  = 3;
  localparam int SRC_BIT  = 2;

  logic                   tick;
  logic [NUNITS-1:0]      evt_fall;
  logic [NUNITS-1:0][1:0] mode_q;
  logic [NUNITS-1:0]      src_q, run_q, flag_q;
  logic [NUNITS-1:0]      inc_lo, inc_hi, wrap_lo, wrap_hi;
  logic [NUNITS-1:0]      wr_ctrl, wr_lo, wr_hi, set_flag;
  logic [NUNITS-1:0][7:0] cnt_lo, cnt_hi;
  logic                   a_split, b_frozen;

  tc_tick_gen u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  assign a_split  = (mode_q[0] == 2'd3);
  assign b_frozen = (mode_q[1] == 2'd3);

  // Register decode: 0/1 control, 2..5 count bytes.
  for (genvar u = 0; u < NUNITS; u++) begin : g_unit
    assign wr_ctrl[u] = reg_wr && (reg_addr == 3'(u));
    assign wr_lo[u]   = reg_wr && (reg_addr == 3'(2 + 2*u));
    assign wr_hi[u]   = reg_wr && (reg_addr == 3'(3 + 2*u));

    tc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(evt_in[u]), .fall(evt_fall[u])
    );

    tc_count_core u_core (
      .clk(clk), .rst_n(rst_n), .mode(tc_mode_e'(mode_q[u])),
      .inc_lo(inc_lo[u]), .inc_hi(inc_hi[u]),
      .wr_lo(wr_lo[u]), .wr_hi(wr_hi[u]), .wdata(reg_wdata),
      .lo_q(cnt_lo[u]), .hi_q(cnt_hi[u]),
      .wrap_lo(wrap_lo[u]), .wrap_hi(wrap_hi[u])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q[u] <= 2'd0;
        src_q[u]  <= 1'b0;
        run_q[u]  <= 1'b0;
        flag_q[u] <= 1'b0;
      end else begin
        if (wr_ctrl[u]) begin
          mode_q[u] <= reg_wdata[1:0];
          src_q[u]  <= reg_wdata[SRC_BIT];
          run_q[u]  <= reg_wdata[RUN_BIT];
        end
        if (set_flag[u])
          flag_q[u] <= 1'b1;
        else if (irq_ack[u] || (wr_ctrl[u] && !reg_wdata[FLAG_BIT]))
          flag_q[u] <= 1'b0;
      end
    end
  end

  // Advance requests.
  assign inc_lo[0] = run_q[0] & (src_q[0] ? evt_fall[0] : tick);
  assign inc_hi[0] = a_split & run_q[1] & tick;
  assign inc_lo[1] = ~b_frozen & run_q[1] & (src_q[1] ? evt_fall[1] : tick);
  assign inc_hi[1] = 1'b0;

  // Flag sources: B's flag is taken over by A's upper half in split.
  assign set_flag[0] = wrap_lo[0];
  assign set_flag[1] = a_split ? wrap_hi[0] : (wrap_lo[1] | wrap_hi[1]);

  assign irq = flag_q;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {3'b000, flag_q[0], run_q[0], src_q[0], mode_q[0]};
      3'd1:    reg_rdata = {3'b000, flag_q[1], run_q[1], src_q[1], mode_q[1]};
      3'd2:    reg_rdata = cnt_lo[0];
      3'd3:    reg_rdata = cnt_hi[0];
      3'd4:    reg_rdata = cnt_lo[1];
      3'd5:    reg_rdata = cnt_hi[1];
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/tc_pair_chk.sv
module tc_pair_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic [1:0] set_flag,
  input logic [1:0] irq,
  input logic [1:0] irq_ack,
  input logic [1:0] mode_a,
  input logic [1:0] mode_b,
  input logic       wrap_a,
  input logic [7:0] a_lo,
  input logic [7:0] a_hi,
  input logic [7:0] b_lo,
  input logic [7:0] b_hi,
  input logic [1:0] wr_lo,
  input logic [1:0] wr_hi
);
  // R3
  tick_alt_chk: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick);
  // R3
  tick_ret_chk: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> tick);
  // R10
  flag_a_set_chk: assert property (@(posedge clk) disable iff (!rst_n) set_flag[0] |=> irq[0]);
  // R10
  flag_b_set_chk: assert property (@(posedge clk) disable iff (!rst_n) set_flag[1] |=> irq[1]);
  // R11
  ack_a_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack[0] && !set_flag[0]) |=> !irq[0]);
  // R11
  ack_b_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack[1] && !set_flag[1]) |=> !irq[1]);
  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_a && mode_a == 2'd2 && !wr_lo[0] && !wr_hi[0]) |=> (a_lo == $past(a_hi)));
  // R7
  b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b == 2'd3 && !wr_lo[1] && !wr_hi[1]) |=> ($stable(b_lo) && $stable(b_hi)));
endmodule

bind tc_pair tc_pair_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .set_flag(set_flag), .irq(irq),
  .irq_ack(irq_ack), .mode_a(mode_q[0]), .mode_b(mode_q[1]), .wrap_a(wrap_lo[0]),
  .a_lo(cnt_lo[0]), .a_hi(cnt_hi[0]), .b_lo(cnt_lo[1]), .b_hi(cnt_hi[1]),
  .wr_lo(wr_lo), .wr_hi(wr_hi)
);

// File: tb/tb_tc_pair.sv
module tb_tc_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] evt_in = '0;
  logic [1:0] irq_ack = '0;
  logic [1:0] irq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  tc_pair dut (.*);

  always #4 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // Control byte: flag bit 4 held at 1 so it is not cleared.
  function automatic logic [7:0] ctl(int m, bit src, bit run);
    return {3'b000, 1'b1, run, src, 2'(m)};
  endfunction

  // Run a unit's control byte for exactly 2n clocks.
  task automatic run_for(logic [2:0] ca, int m, int n);
    wr(ca, ctl(m, 1'b0, 1'b1));
    repeat (2*n - 1) @(negedge clk);
    wr(ca, ctl(m, 1'b0, 1'b0));
  endtask

  // Expected {flag, hi, lo} after n advances.
  function automatic logic [16:0] model(int m, int lo, int hi, int n);
    int v, r, per;
    bit f;
    case (m)
      0: begin
        v = hi*32 + (lo % 32) + n; f = (v >= 8192); v = v % 8192;
        return {f, 8'(v / 32), 8'((lo & 224) | (v % 32))};
      end
      1: begin
        v = hi*256 + lo + n; f = (v >= 65536); v = v % 65536;
        return {f, 8'(v / 256), 8'(v % 256)};
      end
      default: begin
        if (lo + n <= 255) return {1'b0, 8'(hi), 8'(lo + n)};
        r = n - (256 - lo); per = 256 - hi;
        return {1'b1, 8'(hi), 8'(hi + r % per)};
      end
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, lo, hi;
    logic [16:0] e;
    int starts[4][2] = '{'{0, 0}, '{8'hF0, 8'hFF}, '{8'hFC, 8'hFF}, '{8'h35, 8'hC0}};
    int lens[3] = '{1, 7, 40};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin rd(3'(a), d); chk("R1", d, 0); end
    chk("R1 irq", irq, 0);
    // R2 unused addresses
    rd(3'd6, d); chk("R2", d, 0);
    rd(3'd7, d); chk("R2", d, 0);
    // R2 control layout readback
    wr(3'd1, 8'h0E); rd(3'd1, d); chk("R2", d, 8'h0E);
    wr(3'd1, 8'h00);

    // R3 R4 R5 R6 R10 sweep over structures 0..2
    for (int m = 0; m < 3; m++)
      for (int s = 0; s < 4; s++)
        for (int k = 0; k < 3; k++) begin
          wr(3'd0, 8'h00);
          wr(3'd2, 8'(starts[s][0])); wr(3'd3, 8'(starts[s][1]));
          run_for(3'd0, m, lens[k]);
          e = model(m, starts[s][0], starts[s][1], lens[k]);
          rd(3'd2, lo); rd(3'd3, hi);
          chk(m == 0 ? "R4 lo" : m == 1 ? "R5 lo" : "R6 lo", lo, e[7:0]);
          chk(m == 0 ? "R4 hi" : m == 1 ? "R5 hi" : "R6 hi", hi, e[15:8]);
          chk("R10 irq", irq[0], e[16]);
        end

    // R3 run clear: no advance
    wr(3'd0, 8'h01); wr(3'd2, 8'h11); wr(3'd3, 8'h22);
    repeat (20) @(negedge clk);
    rd(3'd2, lo); rd(3'd3, hi); chk("R3 stop", {hi, lo}, 16'h2211);

    // R5 on unit B
    wr(3'd1, 8'h00); wr(3'd4, 8'hFD); wr(3'd5, 8'hFF);
    run_for(3'd1, 1, 5);
    rd(3'd4, lo); rd(3'd5, hi); chk("R5 B", {hi, lo}, 16'h0002);
    chk("R10 B irq", irq[1], 1);

    // R11 acknowledge, write-1 keep, write-0 clear
    wr(3'd0, 8'h00); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    run_for(3'd0, 1, 1);
    chk("R11 set", irq[0], 1);
    irq_ack = 2'b01; @(negedge clk); irq_ack = 2'b00;
    chk("R11 ack", irq[0], 0);
    chk("R11 other", irq[1], 1);
    wr(3'd1, 8'h11); chk("R11 keep", irq[1], 1);
    wr(3'd1, 8'h01); chk("R11 clr", irq[1], 0);

    // R9 external event counting on unit A
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd0, {3'b000, 1'b0, 1'b1, 1'b1, 2'd1});
    for (int p = 0; p < 5; p++) begin
      evt_in[0] = 1'b1; repeat (3) @(negedge clk);
      evt_in[0] = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    rd(3'd2, lo); rd(3'd3, hi); chk("R9", {hi, lo}, 16'h0005);
    wr(3'd0, 8'h01);

    // R8 split on A: lower half alone
    wr(3'd1, 8'h01); wr(3'd2, 8'hF0); wr(3'd3, 8'h10);
    run_for(3'd0, 3, 8);
    rd(3'd2, lo); rd(3'd3, hi); chk("R8 lo", lo, 8'hF8); chk("R8 hi", hi, 8'h10);
    // R8 upper half under B run; B's own wrap sets no flag
    wr(3'd4, 8'hFE); wr(3'd5, 8'hFF);
    run_for(3'd1, 1, 8);
    rd(3'd2, lo); rd(3'd3, hi); chk("R8 lo held", lo, 8'hF8); chk("R8 hi", hi, 8'h18);
    rd(3'd4, lo); rd(3'd5, hi); chk("R8 B count", {hi, lo}, 16'h0006);
    chk("R8 B flag quiet", irq, 0);
    // R8 upper wrap sets B flag
    wr(3'd3, 8'hFC); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    run_for(3'd1, 1, 8);
    rd(3'd3, hi); chk("R8 hi wrap", hi, 8'h04);
    chk("R8 flags", irq, 2'b10);
    wr(3'd1, 8'h01); wr(3'd0, 8'h01);

    // R7 B in structure 3 holds
    wr(3'd4, 8'h34); wr(3'd5, 8'h12);
    run_for(3'd1, 3, 30);
    rd(3'd4, lo); rd(3'd5, hi); chk("R7", {hi, lo}, 16'h1234);
    chk("R7 irq", irq[1], 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule